// File: doc/BRIEF.md
# Guarded Serial Pin Router

This block holds the small configuration state that decides where a four-signal serial port appears on the package pins and which optional pin groups are powered up for the package variant in use. Software reaches it through a plain register bus (write strobe, read strobe, address, write data, registered read data). The block drives one select line per serial signal for each of two pin groups, the raw 3-bit pin-enable code, and two decoded package-group enables.

The assignment register is guarded. Software first writes a 1 into the unlock bit of a separate guard register, then writes the assignment register on a following bus write. Any bus write clears the unlock bit again, so exactly one assignment write is accepted per unlock. An assignment write made while the block is locked changes nothing and raises a sticky error flag that only reset clears.

Top module: `pin_route_ctrl`

## Requirements
- R1: After reset the pin-enable code is 000, the map bit is 0, the unlock bit and error flag are 0, and both package-group enables are 0.
- R2: A write to the guard register (address 0) loads the unlock bit from data bit 0; a read of address 0 returns the unlock bit in bit 0 and the error flag in bit 1, other bits 0.
- R3: A write to the assignment register (address 1) while unlocked loads the pin-enable code from data bits 2:0 and the map bit from data bit 3; the new values appear at the outputs the cycle after the write, and the unlock bit is then 0.
- R4: A write to the assignment register while locked leaves the code and map bit unchanged and sets the error flag.
- R5: Any bus write other than a guard write with data bit 0 set, including a write to an unused address (2 or 3), leaves the block locked.
- R6: With map bit 0 the upper-group selects are all 1 and the lower-group selects all 0; with map bit 1 the reverse. Select index 0 is CTS/RTS, 1 is CLK, 2 is RxD, 3 is TxD, meaning upper pins 4..7 or lower pins 0..3.
- R7: Code 100 asserts only the large-package enable, code 001 asserts only the small-package enable, and every other code leaves both enables 0.
- R8: A read of address 1 returns the code in bits 2:0 and the map bit in bit 3 with other bits 0, on rdData the cycle after rdEn; reads change no state.
- R9: Once set, the error flag stays 1 until reset, whatever is written afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| hiSel | output | 4 | Serial signals routed to upper pins 4..7 |
| loSel | output | 4 | Serial signals routed to lower pins 0..3 |
| pinCode | output | 3 | Current pin-enable code |
| optLarge | output | 1 | Large-package pin group enable |
| optSmall | output | 1 | Small-package pin group enable |
| errFlag | output | 1 | Sticky locked-write error |

## Verification
The bench builds the block with its default widths: an 8-bit data bus, a 2-bit address and four serial signals. At that size every one of the 16 values of the code and map fields can be written both unlocked and locked, so each decode and each route is observed, as is every ignored write. The unused addresses and a guard write of 0 are also reachable, which exercises every way the unlock can be lost.

// File: rtl/pin_route_pkg.sv
package pin_route_pkg;
  parameter int ADDR_W = 2;
  parameter int DATA_W = 8;
  parameter int CODE_W = 3;
  localparam logic [ADDR_W-1:0] GUARD_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ASSIGN_ADDR = ADDR_W'(1);
  localparam int MAP_BIT    = CODE_W;
  localparam int UNLOCK_BIT = 0;
  localparam int ERR_BIT    = 1;
  localparam logic [CODE_W-1:0] CODE_LARGE = CODE_W'(4);
  localparam logic [CODE_W-1:0] CODE_SMALL = CODE_W'(1);

  typedef struct packed {
    logic loadAssign;
    logic flagErr;
  } strobe_t;
endpackage

// File: rtl/pin_route_lock.sv
module pin_route_lock
  import pin_route_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              unlockIn,
  output strobe_t           strobe,
  output logic              unlockQ,
  output logic              errQ
);
  logic guardHit;
  logic assignHit;

  assign guardHit  = wrEn && (addr == GUARD_ADDR);
  assign assignHit = wrEn && (addr == ASSIGN_ADDR);

  always_comb begin
    strobe.loadAssign = assignHit && unlockQ;
    strobe.flagErr    = assignHit && !unlockQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (guardHit)
        unlockQ <= unlockIn;
      else if (wrEn)
        unlockQ <= 1'b0;
      if (strobe.flagErr)
        errQ <= 1'b1;
    end
  end
endmodule

// File: rtl/pin_route_regs.sv
module pin_route_regs
  import pin_route_pkg::*;
#(
  parameter int SIG_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              mapIn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              unlockQ,
  input  logic              errQ,
  output logic [DATA_W-1:0] rdData,
  output logic [SIG_N-1:0]  hiSel,
  output logic [SIG_N-1:0]  loSel,
  output logic [CODE_W-1:0] pinCode,
  output logic              optLarge,
  output logic              optSmall
);
  logic [CODE_W-1:0] codeQ;
  logic              mapQ;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
      mapQ  <= 1'b0;
    end else if (strobe.loadAssign) begin
      codeQ <= codeIn;
      mapQ  <= mapIn;
    end
  end

  for (genvar i = 0; i < SIG_N; i++) begin : g_route
    assign hiSel[i] = !mapQ;
    assign loSel[i] = mapQ;
  end

  assign pinCode  = codeQ;
  assign optLarge = (codeQ == CODE_LARGE);
  assign optSmall = (codeQ == CODE_SMALL);

  always_comb begin
    rdNext = '0;
    if (addr == GUARD_ADDR) begin
      rdNext[UNLOCK_BIT] = unlockQ;
      rdNext[ERR_BIT]    = errQ;
    end else if (addr == ASSIGN_ADDR) begin
      rdNext[CODE_W-1:0] = codeQ;
      rdNext[MAP_BIT]    = mapQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (rdEn)
      rdData <= rdNext;
  end
endmodule

// File: rtl/pin_route_ctrl.sv
module pin_route_ctrl
  import pin_route_pkg::*;
#(
  parameter int SIG_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [SIG_N-1:0]  hiSel,
  output logic [SIG_N-1:0]  loSel,
  output logic [CODE_W-1:0] pinCode,
  output logic              optLarge,
  output logic              optSmall,
  output logic              errFlag
);
  strobe_t strobe;
  logic    unlockQ;
  logic    errQ;

  pin_route_lock u_lock (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .unlockIn (wrData[UNLOCK_BIT]),
    .strobe   (strobe),
    .unlockQ  (unlockQ),
    .errQ     (errQ)
  );

  pin_route_regs #(.SIG_N(SIG_N)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .codeIn   (wrData[CODE_W-1:0]),
    .mapIn    (wrData[MAP_BIT]),
    .rdEn     (rdEn),
    .addr     (addr),
    .unlockQ  (unlockQ),
    .errQ     (errQ),
    .rdData   (rdData),
    .hiSel    (hiSel),
    .loSel    (loSel),
    .pinCode  (pinCode),
    .optLarge (optLarge),
    .optSmall (optSmall)
  );

  assign errFlag = errQ;
endmodule

// File: rtl/pin_route_checker.sv
module pin_route_checker
  import pin_route_pkg::*;
#(
  parameter int SIG_N = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [SIG_N-1:0]  hiSel,
  input logic [SIG_N-1:0]  loSel,
  input logic [CODE_W-1:0] pinCode,
  input logic              optLarge,
  input logic              optSmall,
  input logic              errFlag,
  input logic              unlockQ
);
  logic acceptWr;
  logic lockedWr;
  logic keepUnlock;
  assign acceptWr   = wrEn && (addr == ASSIGN_ADDR) && unlockQ;
  assign lockedWr   = wrEn && (addr == ASSIGN_ADDR) && !unlockQ;
  assign keepUnlock = wrEn && (addr == GUARD_ADDR) && wrData[UNLOCK_BIT];

  // R4
  hold_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acceptWr |=> $stable(pinCode) && $stable(hiSel));

  // R4
  locked_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockedWr |=> errFlag);

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !keepUnlock) |=> !unlockQ);

  // R6
  route_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hiSel & loSel) == '0) && ((hiSel | loSel) == '1));

  // R7
  pkg_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(optLarge && optSmall) && (!optLarge || pinCode == CODE_LARGE)
    && (!optSmall || pinCode == CODE_SMALL));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

bind pin_route_ctrl pin_route_checker #(.SIG_N(SIG_N)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .hiSel    (hiSel),
  .loSel    (loSel),
  .pinCode  (pinCode),
  .optLarge (optLarge),
  .optSmall (optSmall),
  .errFlag  (errFlag),
  .unlockQ  (unlockQ)
);

// File: tb/pin_route_ctrl_test.sv
module pin_route_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [3:0] hiSel;
  logic [3:0] loSel;
  logic [2:0] pinCode;
  logic       optLarge;
  logic       optSmall;
  logic       errFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0] expCode = '0;
  logic       expMap = 1'b0;
  logic       expUnlock = 1'b0;
  logic       expErr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_route_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .hiSel(hiSel), .loSel(loSel),
    .pinCode(pinCode), .optLarge(optLarge), .optSmall(optSmall),
    .errFlag(errFlag)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 2'd0) expUnlock = d[0];
    else begin
      if (a == 2'd1) begin
        if (expUnlock) begin expCode = d[2:0]; expMap = d[3]; end
        else expErr = 1'b1;
      end
      expUnlock = 1'b0;
    end
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic checkOutputs(input string tag);
    check({tag, " R6 hiSel"}, 32'(hiSel), expMap ? 32'h0 : 32'hF);
    check({tag, " R6 loSel"}, 32'(loSel), expMap ? 32'hF : 32'h0);
    check({tag, " R3 pinCode"}, 32'(pinCode), 32'(expCode));
    check({tag, " R7 optLarge"}, 32'(optLarge), 32'(expCode == 3'b100));
    check({tag, " R7 optSmall"}, 32'(optSmall), 32'(expCode == 3'b001));
    check({tag, " R9 errFlag"}, 32'(errFlag), 32'(expErr));
  endtask

  task automatic checkRegs(input string tag);
    logic [7:0] d;
    busRead(2'd1, d);
    check({tag, " R8 assign read"}, 32'(d), 32'({expMap, expCode}));
    busRead(2'd0, d);
    check({tag, " R2 guard read"}, 32'(d), 32'({expErr, expUnlock}));
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkOutputs("R1 reset");
    rstN = 1'b1;
    checkRegs("R1 reset");

    // R4 locked write before any unlock
    busWrite(2'd1, 8'h0C);
    checkOutputs("R4 locked");
    checkRegs("R4 locked");

    for (int v = 0; v < 16; v++) begin
      busWrite(2'd0, 8'h01);
      busRead(2'd0, d);
      check("R2 unlock set", 32'(d[0]), 32'h1);
      busWrite(2'd1, 8'(8'hF0 | v));
      checkOutputs("R3 accepted");
      checkRegs("R3 accepted");
      busWrite(2'd1, 8'(v ^ 15));
      checkOutputs("R4 ignored");
      checkRegs("R4 ignored");
    end

    // R5 unused address write relocks
    for (int a = 2; a < 4; a++) begin
      busWrite(2'd0, 8'h01);
      busWrite(2'(a), 8'hFF);
      busWrite(2'd1, 8'h04);
      checkOutputs("R5 unused addr");
      checkRegs("R5 unused addr");
    end
    // R5 guard write of 0 relocks
    busWrite(2'd0, 8'h01);
    busWrite(2'd0, 8'hFE);
    busWrite(2'd1, 8'h04);
    checkOutputs("R5 guard zero");

    // R9 error survives accepted writes
    busWrite(2'd0, 8'h01);
    busWrite(2'd1, 8'h04);
    checkOutputs("R9 sticky");
    checkRegs("R9 sticky");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule